// File: doc/BRIEF.md
# Interrupt Status Aggregator

This block gathers interrupt requests from several sources into one status register and drives a single level-sensitive interrupt line from it. Hardware sources set status bits with single-cycle pulses. A host write port can also set arbitrary bits to inject interrupts, or clear bits to acknowledge them. The current status is visible on an output bus at all times, and looking at it changes nothing.

Two sources have fixed positions: a compute-completion pulse sets bit 0 and a transfer-completion pulse sets bit 8. Any other bit can be set through the generic hardware set vector. The interrupt line stays high as long as at least one status bit is 1. It drops only after the host has acknowledged every pending bit.

The host port is a plain register write and has no back-pressure. Each cycle with `host_wr` high applies one raise or one acknowledge, chosen by `host_sel`, and takes effect at that clock edge. Status and interrupt outputs are also plain control signals with no handshake.

Top module: `irq_agg`

## Requirements
- R1: A host write with `host_sel` = 0 (raise) ORs `host_wdata` into the status register at that clock edge. Bits that are 0 in the data are left as they were.
- R2: A host write with `host_sel` = 1 (acknowledge) clears every status bit that is 1 in `host_wdata`. All other bits keep their value.
- R3: `irq` is 1 whenever `status` is nonzero and 0 whenever it is zero. It follows `status` with no added delay.
- R4: A `compute_done` pulse sets bit 0 (parameter `COMPUTE_BIT`). A `xfer_done` pulse sets bit 8 (parameter `XFER_BIT`).
- R5: With no host write and no hardware set, `status` holds its value from cycle to cycle. Observing it has no side effect.
- R6: If a hardware set and a host acknowledge hit the same bit in the same cycle, the bit ends up set.
- R7: After reset `status` is zero and `irq` is 0. The status register is `WIDTH` = 32 bits by default.
- R8: Each bit of `hw_set` sets the status bit at the same position at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hw_set | input | WIDTH | Per-bit hardware set pulses |
| compute_done | input | 1 | Compute completion pulse, sets bit COMPUTE_BIT |
| xfer_done | input | 1 | Transfer completion pulse, sets bit XFER_BIT |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | 0 = raise, 1 = acknowledge |
| host_wdata | input | WIDTH | Host write mask |
| status | output | WIDTH | Current status bits |
| irq | output | 1 | Level interrupt, high while any bit is set |

## Verification
The bench builds the block with `WIDTH` = 12, keeping `COMPUTE_BIT` = 0 and `XFER_BIT` = 8. A 12-bit register is narrow enough to walk every single bit through raise, acknowledge and hardware set. It also allows a long arithmetic sweep of mixed masks that covers every bit against every operation. Both fixed source positions stay inside the narrowed register. So the bench can reach same-cycle collisions on the named bits, and the return of `irq` to 0 when the last pending bit is acknowledged.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  typedef enum logic {
    OP_RAISE = 1'b0,
    OP_ACK   = 1'b1
  } host_op_e;
endpackage

// File: rtl/irq_agg_update.sv
module irq_agg_update #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [WIDTH-1:0] set_hw,
  input  logic [WIDTH-1:0] set_sw,
  input  logic [WIDTH-1:0] clr_sw,
  output logic [WIDTH-1:0] nxt
);
  // Per-bit rule: a set of either kind beats an acknowledge on the same bit.
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    always_comb begin
      if (set_hw[i] || set_sw[i]) nxt[i] = 1'b1;
      else if (clr_sw[i])         nxt[i] = 1'b0;
      else                        nxt[i] = cur[i];
    end
  end
endmodule

// File: rtl/irq_agg_reduce.sv
module irq_agg_reduce #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec,
  output logic             any
);
  localparam int HALF = WIDTH / 2;
  if (WIDTH == 1) begin : g_leaf
    assign any = vec[0];
  end else begin : g_split
    logic lo_any, hi_any;
    irq_agg_reduce #(.WIDTH(HALF)) u_lo (
      .vec(vec[HALF-1:0]), .any(lo_any)
    );
    irq_agg_reduce #(.WIDTH(WIDTH-HALF)) u_hi (
      .vec(vec[WIDTH-1:HALF]), .any(hi_any)
    );
    assign any = lo_any | hi_any;
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
#(
  parameter int WIDTH       = 32,
  parameter int COMPUTE_BIT = 0,
  parameter int XFER_BIT    = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] hw_set,
  input  logic             compute_done,
  input  logic             xfer_done,
  input  logic             host_wr,
  input  logic             host_sel,
  input  logic [WIDTH-1:0] host_wdata,
  output logic [WIDTH-1:0] status,
  output logic             irq
);
  localparam logic [WIDTH-1:0] ZERO = '0;

  host_op_e         op;
  logic [WIDTH-1:0] hw_all;
  logic [WIDTH-1:0] sw_raise;
  logic [WIDTH-1:0] sw_ack;
  logic [WIDTH-1:0] status_q;
  logic [WIDTH-1:0] status_d;

  assign op = host_op_e'(host_sel);

  // Merge the fixed-position sources into the generic set vector.
  for (genvar i = 0; i < WIDTH; i++) begin : g_hw
    if (i == COMPUTE_BIT && i == XFER_BIT) begin : g_both
      assign hw_all[i] = hw_set[i] | compute_done | xfer_done;
    end else if (i == COMPUTE_BIT) begin : g_comp
      assign hw_all[i] = hw_set[i] | compute_done;
    end else if (i == XFER_BIT) begin : g_xfer
      assign hw_all[i] = hw_set[i] | xfer_done;
    end else begin : g_plain
      assign hw_all[i] = hw_set[i];
    end
  end

  always_comb begin
    sw_raise = ZERO;
    sw_ack   = ZERO;
    if (host_wr) begin
      if (op == OP_RAISE) sw_raise = host_wdata;
      else                sw_ack   = host_wdata;
    end
  end

  irq_agg_update #(.WIDTH(WIDTH)) u_update (
    .cur    (status_q),
    .set_hw (hw_all),
    .set_sw (sw_raise),
    .clr_sw (sw_ack),
    .nxt    (status_d)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) status_q <= ZERO;
    else        status_q <= status_d;
  end

  irq_agg_reduce #(.WIDTH(WIDTH)) u_reduce (
    .vec (status_q),
    .any (irq)
  );

  assign status = status_q;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
  parameter int WIDTH       = 32,
  parameter int COMPUTE_BIT = 0,
  parameter int XFER_BIT    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic [WIDTH-1:0] hw_set,
  input logic             compute_done,
  input logic             xfer_done,
  input logic             host_wr,
  input logic             host_sel,
  input logic [WIDTH-1:0] host_wdata,
  input logic [WIDTH-1:0] status,
  input logic             irq
);
  logic [WIDTH-1:0] src_mask;
  always_comb begin
    src_mask = hw_set;
    src_mask[COMPUTE_BIT] = src_mask[COMPUTE_BIT] | compute_done;
    src_mask[XFER_BIT]    = src_mask[XFER_BIT] | xfer_done;
  end

  AST_RAISE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && !host_sel) |=> ((status & $past(host_wdata)) == $past(host_wdata))); // R1

  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel) |=> ((status & $past(host_wdata & ~src_mask)) == '0)); // R2

  AST_IRQ_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status != '0)); // R3

  AST_COMPUTE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    compute_done |=> status[COMPUTE_BIT]); // R4

  AST_XFER_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> status[XFER_BIT]); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!host_wr && src_mask == '0) |=> $stable(status)); // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && host_sel) |=> ((status & $past(src_mask)) == $past(src_mask))); // R6

  AST_HW_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_set != '0) |=> ((status & $past(hw_set)) == $past(hw_set))); // R8
endmodule

bind irq_agg irq_agg_chk #(
  .WIDTH(WIDTH), .COMPUTE_BIT(COMPUTE_BIT), .XFER_BIT(XFER_BIT)
) u_irq_agg_chk (
  .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .compute_done(compute_done),
  .xfer_done(xfer_done), .host_wr(host_wr), .host_sel(host_sel),
  .host_wdata(host_wdata), .status(status), .irq(irq)
);

// File: tb/irq_agg_bench.sv
module irq_agg_bench;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 12;
  localparam int CB = 0;
  localparam int XB = 8;
  localparam int WATCHDOG_CYCLES = 20000;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [W-1:0] hw_set = '0;
  logic         compute_done = 1'b0;
  logic         xfer_done = 1'b0;
  logic         host_wr = 1'b0;
  logic         host_sel = 1'b0;
  logic [W-1:0] host_wdata = '0;
  logic [W-1:0] status;
  logic         irq;

  int n_checks = 0;
  int n_fail = 0;
  int cycles = 0;
  logic [W-1:0] model = '0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_agg #(.WIDTH(W), .COMPUTE_BIT(CB), .XFER_BIT(XB)) u_irq_agg (
    .clk(clk), .rst_n(rst_n), .hw_set(hw_set), .compute_done(compute_done),
    .xfer_done(xfer_done), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .status(status), .irq(irq)
  );

  task automatic check(string req);
    n_checks++;
    if (status !== model) begin
      n_fail++;
      $display("FAIL %s status actual=%h expected=%h", req, status, model);
    end
    n_checks++;
    if (irq !== (model != '0)) begin
      n_fail++;
      $display("FAIL R3 (%s) irq actual=%b expected=%b", req, irq, model != '0);
    end
  endtask

  // Apply one cycle of stimulus at negedge, check at the following negedge.
  task automatic step(input logic [W-1:0] hw, input logic cd, input logic xd,
                      input logic wr, input logic sel, input logic [W-1:0] d,
                      input string req);
    logic [W-1:0] set_m;
    hw_set = hw; compute_done = cd; xfer_done = xd;
    host_wr = wr; host_sel = sel; host_wdata = d;
    set_m = hw;
    if (cd) set_m[CB] = 1'b1;
    if (xd) set_m[XB] = 1'b1;
    @(posedge clk);
    @(negedge clk);
    hw_set = '0; compute_done = 1'b0; xfer_done = 1'b0; host_wr = 1'b0;
    if (wr && !sel) model = model | d;
    if (wr && sel)  model = model & ~d;
    model = model | set_m;
    check(req);
  endtask

  initial begin : watchdog
    while (cycles < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    model = '0;
    check("R7");
    rst_n = 1'b1;
    @(negedge clk);
    check("R7");

    // R1 / R2: walk every bit through raise then acknowledge.
    for (int i = 0; i < W; i++) begin
      step('0, 0, 0, 1, 0, W'(1) << i, "R1");
      step('0, 0, 0, 1, 1, W'(1) << i, "R2");
    end

    // R8: walk every bit of the hardware set vector.
    for (int i = 0; i < W; i++) step(W'(1) << i, 0, 0, 0, 0, '0, "R8");
    step('0, 0, 0, 1, 1, '1, "R2");

    // R4: fixed-position sources.
    step('0, 1, 0, 0, 0, '0, "R4");
    step('0, 0, 1, 0, 0, '0, "R4");
    step('0, 0, 0, 1, 1, W'(1) << CB, "R2");
    step('0, 0, 0, 1, 1, W'(1) << XB, "R2");

    // R6: set beats same-cycle acknowledge on each bit and on named sources.
    step('0, 0, 0, 1, 0, '1, "R1");
    for (int i = 0; i < W; i++) step(W'(1) << i, 0, 0, 1, 1, '1, "R6");
    step('0, 1, 1, 1, 1, '1, "R6");
    step('0, 0, 0, 1, 1, '1, "R2");

    // Arithmetic sweep over mixed masks and operations.
    for (int k = 0; k < 600; k++) begin
      logic [W-1:0] d, h;
      d = W'((k * 1103 + 71) % (1 << W));
      h = ((k % 5) == 0) ? W'((k * 37 + 3) % (1 << W)) : '0;
      step(h, (k % 7) == 3, (k % 11) == 4, (k % 3) != 2, (k % 2) == 1, d, "R1");
    end

    // R5: idle cycles keep status untouched.
    step('0, 0, 0, 1, 0, 12'hA5C, "R1");
    for (int k = 0; k < 8; k++) step('0, 0, 0, 0, 0, '0, "R5");
    step('0, 0, 0, 1, 1, '1, "R2");
    for (int k = 0; k < 4; k++) step('0, 0, 0, 0, 0, '0, "R5");

    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end
endmodule